// File: doc/BRIEF.md
# Reset and Low-Power Mode Controller

This block sits beside the processor core of a small microcontroller. It qualifies the external reset pin and produces the internal reset. It also runs the two reduced-power states, idle and power-down. Software requests a state by writing two bits of a power control register. The block then gates the CPU clock, the peripheral clock and the oscillator. It also tells the pad logic how to override each external pin group while the part sleeps.

In idle, the CPU clock stops and the peripherals keep running. An enabled pending interrupt returns the part to normal operation. In power-down, every clock stops and the oscillator is disabled. Only a qualified hardware reset leaves power-down. The pin overrides depend on the state and on whether program memory is internal or external. All logic runs on the oscillator clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `rst_int` rises only after `rst_pin` has been sampled high on `RST_HOLD` (default 24) consecutive rising clock edges. It becomes 1 right after the `RST_HOLD`-th such edge. A shorter pulse has no effect on any output.
- R2: `rst_int` falls after the first edge that samples `rst_pin` low. The FSM leaves RESET for RUN on the following edge. Both request bits read 0 after reset.
- R3: A write (`req_wr`=1) in RUN loads `idle_bit`/`pd_bit` at that edge. The mode takes effect at the next edge, so the CPU clock is still enabled for one cycle after the write. Writes outside RUN are ignored.
- R4: In IDLE, `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_en`=1.
- R5: In IDLE, `irq_pend`=1 returns the FSM to RUN at the next edge and clears `idle_bit`.
- R6: In PDOWN, `cpu_clk_en`=0 and `per_clk_en`=0. `osc_en` equals `rst_pin`, with no clock delay. `irq_pend` has no effect.
- R7: PDOWN is left only through `rst_int` (PDOWN, then RESET, then RUN). `pd_bit` reads 0 afterwards.
- R8: If both request bits are set, the FSM enters PDOWN.
- R9: In IDLE, `strobe_ovr`=1 and `strobe_lvl`=1; in PDOWN, `strobe_ovr`=1 and `strobe_lvl`=0. In RESET and RUN, `strobe_ovr`=0.
- R10: With `ext_prog`=1, `p0_float`=1 in IDLE and PDOWN, and `p2_addr`=1 in IDLE only. With `ext_prog`=0, or in RUN/RESET, both are 0.
- R11: `pwm_high`=1 in IDLE and PDOWN and 0 in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin | input | 1 | External reset pin, active high |
| req_wr | input | 1 | Write strobe for the power control bits |
| req_idle | input | 1 | Idle request bit value written |
| req_pd | input | 1 | Power-down request bit value written |
| irq_pend | input | 1 | An enabled interrupt is pending |
| ext_prog | input | 1 | 1 = program memory is external |
| rst_int | output | 1 | Qualified internal reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| strobe_ovr | output | 1 | Override address-latch and program-store strobes |
| strobe_lvl | output | 1 | Level forced on both strobes when overridden |
| p0_float | output | 1 | Float the low address/data port |
| p2_addr | output | 1 | High port keeps driving the address |
| pwm_high | output | 1 | Force both PWM outputs high |
| idle_bit | output | 1 | Idle request bit readback |
| pd_bit | output | 1 | Power-down request bit readback |

## Verification
Clock and pin overrides are Moore outputs of the state, so they change one edge after the event that moves the FSM. A mode write therefore shows in the request bits after its own edge and in the enables one edge later. Wake-up and the RESET-to-RUN step each take one edge. `rst_int` rises right after the 24th high sample and falls right after the first low sample. `osc_en` follows the pin at once in power-down. The bench drives inputs on falling edges and samples each result at the falling edge that follows the exact number of rising edges given here. For example, it checks that `rst_int` is still 0 after 23 edges and is 1 after 24.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_IDLE  = 2'd2,
        ST_PDOWN = 2'd3
    } pm_state_t;
endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
    parameter int RST_HOLD = 24
) (
    input  logic clk_osc,
    input  logic rst_pin,
    output logic rst_int
);
    localparam int CW = $clog2(RST_HOLD + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(RST_HOLD);

    logic [CW-1:0] cnt_q;

    // Saturating run-length counter of high pin samples
    always_ff @(posedge clk_osc) begin
        if (!rst_pin)
            cnt_q <= '0;
        else if (cnt_q != HOLD_V)
            cnt_q <= cnt_q + 1'b1;
    end

    assign rst_int = (cnt_q == HOLD_V);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk_osc,
    input  logic      rst_int,
    input  logic      req_wr,
    input  logic      req_idle,
    input  logic      req_pd,
    input  logic      irq_pend,
    output pm_state_t state,
    output logic      idle_bit,
    output logic      pd_bit
);
    pm_state_t state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_RESET: state_d = ST_RUN;
            ST_RUN: begin
                if (pd_bit)        state_d = ST_PDOWN;
                else if (idle_bit) state_d = ST_IDLE;
            end
            ST_IDLE:  if (irq_pend) state_d = ST_RUN;
            ST_PDOWN: state_d = ST_PDOWN;
        endcase
    end

    always_ff @(posedge clk_osc) begin
        if (rst_int) state <= ST_RESET;
        else         state <= state_d;
    end

    // Power control request bits
    always_ff @(posedge clk_osc) begin
        if (rst_int) begin
            idle_bit <= 1'b0;
            pd_bit   <= 1'b0;
        end else if (state == ST_RUN && req_wr) begin
            idle_bit <= req_idle;
            pd_bit   <= req_pd;
        end else if (state == ST_IDLE && irq_pend) begin
            idle_bit <= 1'b0;
            pd_bit   <= 1'b0;
        end
    end
endmodule

// File: rtl/pin_override.sv
module pin_override
    import pwr_mode_pkg::*;
(
    input  pm_state_t state,
    input  logic      ext_prog,
    input  logic      rst_pin,
    output logic      cpu_clk_en,
    output logic      per_clk_en,
    output logic      osc_en,
    output logic      strobe_ovr,
    output logic      strobe_lvl,
    output logic      p0_float,
    output logic      p2_addr,
    output logic      pwm_high
);
    always_comb begin
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        osc_en     = 1'b1;
        strobe_ovr = 1'b0;
        strobe_lvl = 1'b0;
        p0_float   = 1'b0;
        p2_addr    = 1'b0;
        pwm_high   = 1'b0;
        unique case (state)
            ST_RESET, ST_RUN: ;
            ST_IDLE: begin
                cpu_clk_en = 1'b0;
                strobe_ovr = 1'b1;
                strobe_lvl = 1'b1;
                p0_float   = ext_prog;
                p2_addr    = ext_prog;
                pwm_high   = 1'b1;
            end
            ST_PDOWN: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
                osc_en     = rst_pin;
                strobe_ovr = 1'b1;
                strobe_lvl = 1'b0;
                p0_float   = ext_prog;
                pwm_high   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int RST_HOLD = 24
) (
    input  logic clk_osc,
    input  logic rst_pin,
    input  logic req_wr,
    input  logic req_idle,
    input  logic req_pd,
    input  logic irq_pend,
    input  logic ext_prog,
    output logic rst_int,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic strobe_ovr,
    output logic strobe_lvl,
    output logic p0_float,
    output logic p2_addr,
    output logic pwm_high,
    output logic idle_bit,
    output logic pd_bit
);
    pm_state_t state;

    rst_qual #(.RST_HOLD(RST_HOLD)) u_rst_qual (
        .clk_osc (clk_osc),
        .rst_pin (rst_pin),
        .rst_int (rst_int)
    );

    pwr_mode_fsm u_fsm (
        .clk_osc  (clk_osc),
        .rst_int  (rst_int),
        .req_wr   (req_wr),
        .req_idle (req_idle),
        .req_pd   (req_pd),
        .irq_pend (irq_pend),
        .state    (state),
        .idle_bit (idle_bit),
        .pd_bit   (pd_bit)
    );

    pin_override u_pins (
        .state      (state),
        .ext_prog   (ext_prog),
        .rst_pin    (rst_pin),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en),
        .osc_en     (osc_en),
        .strobe_ovr (strobe_ovr),
        .strobe_lvl (strobe_lvl),
        .p0_float   (p0_float),
        .p2_addr    (p2_addr),
        .pwm_high   (pwm_high)
    );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
    import pwr_mode_pkg::*;
#(
    parameter int RST_HOLD = 24
) (
    input logic      clk_osc,
    input logic      rst_pin,
    input logic      irq_pend,
    input logic      rst_int,
    input pm_state_t state,
    input logic      cpu_clk_en,
    input logic      per_clk_en,
    input logic      strobe_ovr,
    input logic      strobe_lvl,
    input logic      pwm_high,
    input logic      idle_bit,
    input logic      pd_bit
);
    int unsigned run_len = 0;
    always_ff @(posedge clk_osc) begin
        if (!rst_pin)                           run_len <= 0;
        else if (run_len < RST_HOLD + 2)        run_len <= run_len + 1;
    end

    assert_rst_qualified_R1: assert property (@(posedge clk_osc)
        $rose(rst_int) |-> run_len >= RST_HOLD);

    assert_idle_clocks_R4: assert property (@(posedge clk_osc) disable iff (rst_int)
        state == ST_IDLE |-> (!cpu_clk_en && per_clk_en));

    assert_idle_wake_R5: assert property (@(posedge clk_osc) disable iff (rst_int)
        (state == ST_IDLE && irq_pend) |=> (state == ST_RUN && !idle_bit));

    assert_pd_sticky_R7: assert property (@(posedge clk_osc) disable iff (rst_int)
        state == ST_PDOWN |=> state == ST_PDOWN);

    assert_pd_priority_R8: assert property (@(posedge clk_osc) disable iff (rst_int)
        (state == ST_RUN && idle_bit && pd_bit) |=> state == ST_PDOWN);

    assert_strobe_lvl_R9: assert property (@(posedge clk_osc) disable iff (rst_int)
        state == ST_PDOWN |-> (strobe_ovr && !strobe_lvl && !per_clk_en));

    assert_pwm_high_R11: assert property (@(posedge clk_osc) disable iff (rst_int)
        (state == ST_IDLE || state == ST_PDOWN) |-> pwm_high);
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.RST_HOLD(RST_HOLD)) u_chk (
    .clk_osc    (clk_osc),
    .rst_pin    (rst_pin),
    .irq_pend   (irq_pend),
    .rst_int    (rst_int),
    .state      (state),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .strobe_ovr (strobe_ovr),
    .strobe_lvl (strobe_lvl),
    .pwm_high   (pwm_high),
    .idle_bit   (idle_bit),
    .pd_bit     (pd_bit)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    logic clk_osc = 1'b0;
    logic rst_pin = 1'b1, req_wr = 1'b0, req_idle = 1'b0, req_pd = 1'b0;
    logic irq_pend = 1'b0, ext_prog = 1'b0;
    logic rst_int, cpu_clk_en, per_clk_en, osc_en, strobe_ovr, strobe_lvl;
    logic p0_float, p2_addr, pwm_high, idle_bit, pd_bit;
    int n_chk = 0, n_fail = 0;

    always #5 clk_osc = ~clk_osc;

    pwr_mode_ctrl i_pwr_mode_ctrl (
        .clk_osc(clk_osc), .rst_pin(rst_pin), .req_wr(req_wr), .req_idle(req_idle),
        .req_pd(req_pd), .irq_pend(irq_pend), .ext_prog(ext_prog),
        .rst_int(rst_int), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .strobe_ovr(strobe_ovr), .strobe_lvl(strobe_lvl),
        .p0_float(p0_float), .p2_addr(p2_addr), .pwm_high(pwm_high),
        .idle_bit(idle_bit), .pd_bit(pd_bit)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk_osc);
        @(negedge clk_osc);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // R1 R2: full reset sequence, ends in RUN
    task automatic t_reset;
        rst_pin = 1'b1;
        edges(RST_EDGES - 1);
        chk("R1 not yet", {7'd0, rst_int}, 8'd0);
        edges(1);
        chk("R1 asserted", {7'd0, rst_int}, 8'd1);
        rst_pin = 1'b0;
        edges(1);
        chk("R2 released", {7'd0, rst_int}, 8'd0);
        edges(1);
        chk("R2 bits clear", {6'd0, idle_bit, pd_bit}, 8'd0);
        chk("R2 run outputs", {4'd0, cpu_clk_en, per_clk_en, osc_en, strobe_ovr}, 8'b1110);
        chk("R11 pwm run", {7'd0, pwm_high}, 8'd0);
    endtask
    localparam int RST_EDGES = 24;

    task automatic write_req(input logic i, input logic p);
        req_wr = 1'b1; req_idle = i; req_pd = p;
        edges(1);
        req_wr = 1'b0; req_idle = 1'b0; req_pd = 1'b0;
    endtask

    task automatic t_idle;
        ext_prog = 1'b1;
        write_req(1'b1, 1'b0);
        chk("R3 bit loaded", {6'd0, idle_bit, pd_bit}, 8'b10);
        chk("R3 cpu still on", {7'd0, cpu_clk_en}, 8'd1);
        edges(1);
        chk("R4 idle clocks", {5'd0, cpu_clk_en, per_clk_en, osc_en}, 8'b011);
        chk("R9 idle strobes", {6'd0, strobe_ovr, strobe_lvl}, 8'b11);
        chk("R10 idle ext ports", {6'd0, p0_float, p2_addr}, 8'b11);
        chk("R11 pwm idle", {7'd0, pwm_high}, 8'd1);
        ext_prog = 1'b0;
        #1 chk("R10 idle int ports", {6'd0, p0_float, p2_addr}, 8'b00);
        // write while idle is ignored
        write_req(1'b0, 1'b1);
        chk("R3 write ignored", {6'd0, idle_bit, pd_bit}, 8'b10);
        chk("R3 still idle", {7'd0, cpu_clk_en}, 8'd0);
        // short reset pulse ignored
        rst_pin = 1'b1;
        edges(RST_EDGES - 1);
        rst_pin = 1'b0;
        edges(2);
        chk("R1 short pulse", {6'd0, rst_int, cpu_clk_en}, 8'b00);
        irq_pend = 1'b1;
        edges(1);
        irq_pend = 1'b0;
        chk("R5 wake", {6'd0, cpu_clk_en, idle_bit}, 8'b10);
    endtask

    task automatic t_pdown(input logic both);
        ext_prog = 1'b1;
        write_req(both, 1'b1);
        edges(1);
        chk(both ? "R8 priority" : "R6 pd clocks",
            {5'd0, cpu_clk_en, per_clk_en, osc_en}, 8'b000);
        chk("R9 pd strobes", {6'd0, strobe_ovr, strobe_lvl}, 8'b10);
        chk("R10 pd ext ports", {6'd0, p0_float, p2_addr}, 8'b10);
        chk("R11 pwm pd", {7'd0, pwm_high}, 8'd1);
        irq_pend = 1'b1;
        edges(3);
        irq_pend = 1'b0;
        chk("R6 irq ignored", {6'd0, cpu_clk_en, per_clk_en}, 8'b00);
        chk("R7 still pd", {7'd0, osc_en}, 8'd0);
        rst_pin = 1'b1;
        #1 chk("R6 osc follows pin", {7'd0, osc_en}, 8'd1);
        edges(RST_EDGES);
        chk("R7 reset reached", {7'd0, rst_int}, 8'd1);
        rst_pin = 1'b0;
        edges(2);
        chk("R7 back to run", {5'd0, cpu_clk_en, per_clk_en, pd_bit}, 8'b110);
        ext_prog = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_pin = 1'b0;
        edges(2);
        t_reset();
        t_idle();
        t_pdown(1'b0);
        t_pdown(1'b1);
        t_idle();
        finish_run();
    end
endmodule